// File: doc/BRIEF.md
# Mixed-Precision Brain-Float Fused Multiply-Add

This block computes d = c + a*b, where a and b are 16-bit brain-float operands (sign, 8-bit exponent, 7 stored fraction bits) and c and d are single-precision values (sign, 8-bit exponent, 23 stored fraction bits). Both formats use the same exponent bias of 127. The two 8-bit significands multiply exactly into 16 bits. The product is then aligned against c and added in a wide fixed-point window, so the only rounding is the final round-to-nearest-even to a 24-bit significand.

Operands are accepted every cycle. A result leaves on `outValid` exactly three cycles after its operands were presented with `inValid`. The three register stages are: product and exponent sum; alignment and signed add; normalization, rounding and special-value selection. Values with a zero exponent field are taken as zero on input, and results below the smallest normal value leave as a signed zero. Two result flags are provided. `invOut` marks an invalid operation and `ovfOut` marks a rounding overflow to infinity.

Top module: `bf16_fma`

## Requirements
- R1: A cycle with `inValid` high produces `outValid` high exactly 3 cycles later, and only then. `inReady` is high in every cycle after reset.
- R2: For finite normal inputs, `dOut` is the single-precision encoding (bit 31 sign, bits 30:23 biased exponent, bits 22:0 fraction) of c + a*b, rounded once. This holds for addition, for subtraction where either term dominates, and for equal exponents where the sign flips.
- R3: Rounding is to nearest, with ties going to the even significand. A round-up that carries out of the significand increments the exponent.
- R4: Any NaN input (exponent all ones, fraction nonzero) yields 0x7FC00000 with `invOut` low.
- R5: Infinity times zero, or a sum of an infinite product and an infinite c of opposite signs, yields 0x7FC00000 with `invOut` high.
- R6: An infinite product or infinite c that raises no R5 case yields an infinity with that operand's sign and `ovfOut` low.
- R7: A finite result whose exponent after rounding reaches 255 yields a signed infinity (0x7F800000 or 0xFF800000) with `ovfOut` high. A result at the largest finite values does not set the flag.
- R8: Any input with a zero exponent field is treated as a zero of its sign, whatever its fraction.
- R9: A nonzero result whose exponent after rounding is 0 or less leaves as a zero that keeps the result sign. `dOut` never carries a subnormal encoding.
- R10: An exact zero sum is +0 when the two terms have opposite signs, and -0 only when both terms are -0.
- R11: After reset, `outValid`, `dOut`, `ovfOut` and `invOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands a, b and c are presented this cycle |
| inReady | output | 1 | The unit accepts operands (high after reset) |
| aIn | input | 16 | Brain-float multiplicand |
| bIn | input | 16 | Brain-float multiplier |
| cIn | input | 32 | Single-precision addend |
| outValid | output | 1 | `dOut` and the flags hold a new result |
| dOut | output | 32 | Single-precision result |
| ovfOut | output | 1 | The result overflowed to infinity |
| invOut | output | 1 | The operation was invalid and the result is NaN |

## Verification
Every result is due in the cycle exactly three clock edges after the edge that took its operands. Each driven operation records its issue cycle in a scoreboard entry. The monitor samples at the falling edge and compares the arrival cycle of each `outValid` against that issue cycle plus three, so an early, late or spurious result fails, as well as a wrong value or flag. Operations are issued back to back and also with idle gaps. This covers both a full pipeline and isolated results.

// File: rtl/bf16_fma_pkg.sv
package bf16_fma_pkg;
  parameter int EXP_W     = 8;
  parameter int BF_FRAC_W = 7;
  parameter int SP_FRAC_W = 23;

  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam int BF_W     = 1 + EXP_W + BF_FRAC_W;
  localparam int SP_W     = 1 + EXP_W + SP_FRAC_W;
  localparam int BF_SIG_W = BF_FRAC_W + 1;
  localparam int PROD_W   = 2 * BF_SIG_W;
  localparam int SP_SIG_W = SP_FRAC_W + 1;
  localparam int PROD_SH  = SP_FRAC_W - 2 * BF_FRAC_W;   // product point moved to SP point
  localparam int ALN_X_W  = SP_SIG_W + 1;                // magnitude up to [0,4)
  localparam int EXTRA_W  = ALN_X_W + 1;                 // guard space below big operand
  localparam int ACC_W    = 1 + ALN_X_W + EXTRA_W;       // carry + operand + low bits
  localparam int ONE_POS  = EXTRA_W + SP_FRAC_W;         // bit weight of 1.0 in ACC
  localparam int EW       = EXP_W + 3;                   // signed exponent width
  localparam int ZERO_EXP = -(3 * BIAS);                 // below any real exponent
  localparam int SH_W     = $clog2(ACC_W + 1);

  localparam logic [SP_W-1:0] SP_QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } strobe_t;

  typedef struct packed {
    logic                 pSign;
    logic [PROD_W-1:0]    pSig;
    logic signed [EW-1:0] pExp;
    logic                 cSign;
    logic [SP_SIG_W-1:0]  cSig;
    logic signed [EW-1:0] cExp;
    logic                 isNan;
    logic                 isInv;
    logic                 pInf;
    logic                 cInf;
  } stage1_t;

  typedef struct packed {
    logic [ACC_W-1:0]     mag;
    logic                 sumSign;
    logic                 zeroSign;
    logic signed [EW-1:0] sumExp;
    logic                 isNan;
    logic                 isInv;
    logic                 isInf;
    logic                 infSign;
  } stage2_t;
endpackage

// File: rtl/bf16_fma_ctrl.sv
module bf16_fma_ctrl
  import bf16_fma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  output strobe_t stb
);
  logic [2:0] vPipe;
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe    <= '0;
      sinceRst <= '0;
    end else begin
      vPipe <= {vPipe[1:0], inValid};
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
    end
  end

  assign inReady  = rstN;
  assign stb.ld1  = inValid;
  assign stb.ld2  = vPipe[0];
  assign stb.ld3  = vPipe[1];
  assign outValid = vPipe[2];

  // R1: result valid follows accepted operands by exactly three edges
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));
endmodule

// File: rtl/bf16_fma_dp.sv
module bf16_fma_dp
  import bf16_fma_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [BF_W-1:0] aIn,
  input  logic [BF_W-1:0] bIn,
  input  logic [SP_W-1:0] cIn,
  output logic [SP_W-1:0] dOut,
  output logic            ovfOut,
  output logic            invOut
);
  stage1_t s1, s1Next;
  stage2_t s2, s2Next;

  // ---------------- stage 1: decode, multiply, exponent sum
  always_comb begin
    logic [EXP_W-1:0]     aExp, bExp, cExp;
    logic [BF_FRAC_W-1:0] aFrac, bFrac;
    logic [SP_FRAC_W-1:0] cFrac;
    logic aZ, bZ, cZ, aI, bI, cI, aN, bN, cN, pZ, pI, invMul, invAdd, anyNan;
    aExp  = aIn[BF_W-2 -: EXP_W];
    bExp  = bIn[BF_W-2 -: EXP_W];
    cExp  = cIn[SP_W-2 -: EXP_W];
    aFrac = aIn[BF_FRAC_W-1:0];
    bFrac = bIn[BF_FRAC_W-1:0];
    cFrac = cIn[SP_FRAC_W-1:0];
    aZ = (aExp == '0);
    bZ = (bExp == '0);
    cZ = (cExp == '0);
    aI = (aExp == EXP_MAX[EXP_W-1:0]) && (aFrac == '0);
    bI = (bExp == EXP_MAX[EXP_W-1:0]) && (bFrac == '0);
    cI = (cExp == EXP_MAX[EXP_W-1:0]) && (cFrac == '0);
    aN = (aExp == EXP_MAX[EXP_W-1:0]) && (aFrac != '0);
    bN = (bExp == EXP_MAX[EXP_W-1:0]) && (bFrac != '0);
    cN = (cExp == EXP_MAX[EXP_W-1:0]) && (cFrac != '0);
    pZ = aZ | bZ;
    pI = aI | bI;
    anyNan = aN | bN | cN;
    s1Next.pSign = aIn[BF_W-1] ^ bIn[BF_W-1];
    s1Next.cSign = cIn[SP_W-1];
    invMul = (aI & bZ) | (bI & aZ);
    invAdd = pI & cI & (s1Next.pSign != s1Next.cSign);
    s1Next.isInv = (invMul | invAdd) & ~anyNan;
    s1Next.isNan = anyNan | s1Next.isInv;
    s1Next.pInf  = pI;
    s1Next.cInf  = cI;
    s1Next.pSig  = pZ ? '0 : PROD_W'({1'b1, aFrac} * {1'b1, bFrac});
    s1Next.pExp  = pZ ? EW'(ZERO_EXP)
                      : EW'(int'(aExp) + int'(bExp) - BIAS);
    s1Next.cSig  = cZ ? '0 : {1'b1, cFrac};
    s1Next.cExp  = cZ ? EW'(ZERO_EXP) : EW'(int'(cExp));
  end

  // ---------------- stage 2: align smaller term, signed add
  always_comb begin
    logic [ALN_X_W-1:0]   pX, cX, bigX, smallX;
    logic signed [EW-1:0] bigE, smallE, diffE;
    logic                 pBig, bigS, smallS, lost, neg;
    logic [SH_W-1:0]      shAmt;
    logic [ACC_W-1:0]     bigV, smallV, shifted, aligned;
    logic [ACC_W:0]       raw;
    pX   = {s1.pSig, {PROD_SH{1'b0}}};
    cX   = {1'b0, s1.cSig};
    pBig = (s1.pExp >= s1.cExp);
    bigX   = pBig ? pX : cX;
    smallX = pBig ? cX : pX;
    bigE   = pBig ? s1.pExp : s1.cExp;
    smallE = pBig ? s1.cExp : s1.pExp;
    bigS   = pBig ? s1.pSign : s1.cSign;
    smallS = pBig ? s1.cSign : s1.pSign;
    diffE  = bigE - smallE;
    shAmt  = (diffE > EW'(ACC_W)) ? SH_W'(ACC_W) : diffE[SH_W-1:0];
    bigV    = {1'b0, bigX, {EXTRA_W{1'b0}}};
    smallV  = {1'b0, smallX, {EXTRA_W{1'b0}}};
    shifted = smallV >> shAmt;
    lost    = |(smallV & ~({ACC_W{1'b1}} << shAmt));
    aligned = shifted | {{(ACC_W-1){1'b0}}, lost};
    if (bigS ^ smallS) raw = {1'b0, bigV} - {1'b0, aligned};
    else               raw = {1'b0, bigV} + {1'b0, aligned};
    neg = raw[ACC_W];
    s2Next.mag      = neg ? (~raw[ACC_W-1:0] + 1'b1) : raw[ACC_W-1:0];
    s2Next.sumSign  = bigS ^ neg;
    s2Next.zeroSign = s1.pSign & s1.cSign;
    s2Next.sumExp   = bigE;
    s2Next.isNan    = s1.isNan;
    s2Next.isInv    = s1.isInv;
    s2Next.isInf    = s1.pInf | s1.cInf;
    s2Next.infSign  = s1.pInf ? s1.pSign : s1.cSign;
  end

  // ---------------- stage 3: normalize, round, select specials
  logic [SP_W-1:0] dNext;
  logic            ovfNext, invNext;

  always_comb begin
    int                  lead, resE;
    logic [ACC_W-1:0]    norm;
    logic [SP_SIG_W-1:0] mant;
    logic [SP_SIG_W:0]   rounded;
    logic                guard, sticky, lsb, carry;
    logic [SP_FRAC_W-1:0] frac;
    lead = 0;
    for (int i = 0; i < ACC_W; i++)
      if (s2.mag[i]) lead = i;
    norm    = s2.mag << (ACC_W - 1 - lead);
    mant    = norm[ACC_W-1 -: SP_SIG_W];
    lsb     = norm[ACC_W-SP_SIG_W];
    guard   = norm[ACC_W-1-SP_SIG_W];
    sticky  = |norm[ACC_W-2-SP_SIG_W:0];
    rounded = {1'b0, mant} + {{SP_SIG_W{1'b0}}, guard & (sticky | lsb)};
    carry   = rounded[SP_SIG_W];
    frac    = carry ? '0 : rounded[SP_FRAC_W-1:0];
    resE    = int'(s2.sumExp) + lead - ONE_POS + int'(carry);
    ovfNext = 1'b0;
    invNext = 1'b0;
    if (s2.isNan) begin
      dNext   = SP_QNAN;
      invNext = s2.isInv;
    end else if (s2.isInf) begin
      dNext = {s2.infSign, {EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
    end else if (s2.mag == '0) begin
      dNext = {s2.zeroSign, {(SP_W-1){1'b0}}};
    end else if (resE >= EXP_MAX) begin
      dNext   = {s2.sumSign, {EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
      ovfNext = 1'b1;
    end else if (resE <= 0) begin
      dNext = {s2.sumSign, {(SP_W-1){1'b0}}};
    end else begin
      dNext = {s2.sumSign, resE[EXP_W-1:0], frac};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1     <= '0;
      s2     <= '0;
      dOut   <= '0;
      ovfOut <= 1'b0;
      invOut <= 1'b0;
    end else begin
      if (stb.ld1) s1 <= s1Next;
      if (stb.ld2) s2 <= s2Next;
      if (stb.ld3) begin
        dOut   <= dNext;
        ovfOut <= ovfNext;
        invOut <= invNext;
      end
    end
  end

  // R5: an invalid flag always travels with the canonical NaN
  a_r5_inv_is_nan: assert property (@(posedge clk) disable iff (!rstN)
    invOut |-> (dOut == SP_QNAN));
  // R7: overflow flag only with an infinite result
  a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut |-> (dOut[SP_W-2:0] == {{EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}}));
  // R9: no subnormal encoding ever leaves the unit
  a_r9_no_subnormal: assert property (@(posedge clk) disable iff (!rstN)
    !((dOut[SP_W-2 -: EXP_W] == '0) && (dOut[SP_FRAC_W-1:0] != '0)));
  // R5: both flags never rise together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfOut && invOut));
endmodule

// File: rtl/bf16_fma.sv
module bf16_fma
  import bf16_fma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [15:0] aIn,
  input  logic [15:0] bIn,
  input  logic [31:0] cIn,
  output logic        outValid,
  output logic [31:0] dOut,
  output logic        ovfOut,
  output logic        invOut
);
  strobe_t stb;

  bf16_fma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  bf16_fma_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .aIn    (aIn),
    .bIn    (bIn),
    .cIn    (cIn),
    .dOut   (dOut),
    .ovfOut (ovfOut),
    .invOut (invOut)
  );
endmodule

// File: tb/bf16_fma_tb.sv
`timescale 1ns/1ps
module bf16_fma_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] aIn = '0;
  logic [15:0] bIn = '0;
  logic [31:0] cIn = '0;
  logic        outValid;
  logic [31:0] dOut;
  logic        ovfOut, invOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] d;
    logic        ovf;
    logic        inv;
    int          issue;
    string       tag;
  } exp_t;
  exp_t sbQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bf16_fma u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .aIn(aIn), .bIn(bIn), .cIn(cIn), .outValid(outValid),
    .dOut(dOut), .ovfOut(ovfOut), .invOut(invOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b,
                      input logic [31:0] c, input logic [31:0] d,
                      input logic ovf, input logic inv, input string tag);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; aIn = a; bIn = b; cIn = c;
    e.d = d; e.ovf = ovf; e.inv = inv; e.issue = cyc; e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; aIn = 16'hFFFF; bIn = 16'hFFFF; cIn = 32'hFFFFFFFF;
    end
  endtask

  // Monitor: pops the oldest expectation whenever a result appears
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R1", "spurious outValid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check(cyc == e.issue + 3, "R1", "latency", cyc, e.issue + 3);
        check(dOut == e.d, e.tag, "dOut", dOut, e.d);
        check({ovfOut, invOut} == {e.ovf, e.inv}, e.tag, "flags {ovf,inv}",
              {30'd0, ovfOut, invOut}, {30'd0, e.ovf, e.inv});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(outValid == 1'b0, "R11", "outValid in reset", outValid, 0);
    check(dOut == 32'd0, "R11", "dOut in reset", dOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({outValid, ovfOut, invOut} == 3'b000, "R11", "outputs after reset",
          {outValid, ovfOut, invOut}, 0);
    check(inReady == 1'b1, "R1", "inReady", inReady, 1);

    // R2: exact fused results, back to back
    send(16'h3FC0, 16'h4000, 32'h3F800000, 32'h40800000, 0, 0, "R2");
    send(16'h3F81, 16'h3F81, 32'h00000000, 32'h3F820200, 0, 0, "R2");
    send(16'h3F81, 16'h3F81, 32'hBF800000, 32'h3C808000, 0, 0, "R2");
    send(16'h4000, 16'h4000, 32'hBF800000, 32'h40400000, 0, 0, "R2");
    send(16'h3F80, 16'h3F80, 32'hC0400000, 32'hC0000000, 0, 0, "R2");
    send(16'h3F80, 16'h3F80, 32'hBFC00000, 32'hBF000000, 0, 0, "R2");
    idle(2);
    // R3: round to nearest even
    send(16'h3380, 16'h3F80, 32'h3F800000, 32'h3F800000, 0, 0, "R3");
    send(16'h3380, 16'h3F80, 32'h3F800001, 32'h3F800002, 0, 0, "R3");
    send(16'h33C0, 16'h3F80, 32'h3F800000, 32'h3F800001, 0, 0, "R3");
    send(16'h3380, 16'h3F80, 32'h3FFFFFFF, 32'h40000000, 0, 0, "R3");
    send(16'hA180, 16'h3F80, 32'h3F800000, 32'h3F800000, 0, 0, "R3");
    idle(1);
    // R4 / R5: NaN handling
    send(16'h7FC1, 16'h3F80, 32'h3F800000, 32'h7FC00000, 0, 0, "R4");
    send(16'h3F80, 16'h3F80, 32'h7F800001, 32'h7FC00000, 0, 0, "R4");
    send(16'h7F80, 16'h0000, 32'h3F800000, 32'h7FC00000, 0, 1, "R5");
    send(16'h7F80, 16'h3F80, 32'hFF800000, 32'h7FC00000, 0, 1, "R5");
    // R6: infinity propagation
    send(16'hFF80, 16'h4000, 32'h3F800000, 32'hFF800000, 0, 0, "R6");
    send(16'h3F80, 16'h3F80, 32'h7F800000, 32'h7F800000, 0, 0, "R6");
    send(16'h7F80, 16'h3F80, 32'h7F800000, 32'h7F800000, 0, 0, "R6");
    idle(3);
    // R7: overflow and its boundary
    send(16'h7F7F, 16'h4000, 32'h00000000, 32'h7F800000, 1, 0, "R7");
    send(16'h7F7F, 16'hC000, 32'h00000000, 32'hFF800000, 1, 0, "R7");
    send(16'h7F7F, 16'h3F80, 32'h00000000, 32'h7F7F0000, 0, 0, "R7");
    // R8: zero-exponent inputs read as zero
    send(16'h0001, 16'h3F80, 32'h40400000, 32'h40400000, 0, 0, "R8");
    send(16'h0000, 16'h0000, 32'h00000005, 32'h00000000, 0, 0, "R8");
    send(16'h8040, 16'h3F80, 32'hC0000000, 32'hC0000000, 0, 0, "R8");
    // R9: tiny results flushed with sign
    send(16'h0080, 16'hBF00, 32'h00000000, 32'h80000000, 0, 0, "R9");
    send(16'h0080, 16'h3F00, 32'h00000000, 32'h00000000, 0, 0, "R9");
    // R10: zero sign rules
    send(16'h4040, 16'hBF80, 32'h40400000, 32'h00000000, 0, 0, "R10");
    send(16'hBF80, 16'h0000, 32'h80000000, 32'h80000000, 0, 0, "R10");
    send(16'h0000, 16'h0000, 32'h00000000, 32'h00000000, 0, 0, "R10");
    idle(8);
    check(sbQ.size() == 0, "R1", "results outstanding", sbQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule